// File: doc/BRIEF.md
# Serial Register Access Slave

This block gives a host read and write access to a small bank of 8-bit control and status registers over a clocked serial link. The host frames each transaction with an active-low select. Within the frame it sends one direction bit, a 6-bit register address, one filler bit, and then an 8-bit data field, so every frame is 16 serial clocks long. On a write, the host supplies the data field. On a read, the slave returns the addressed register on its serial output during the data phase.

The serial clock, select and data input are brought into the fabric clock domain through synchronizers, and both serial clock edges are detected there. Eight read-write control registers drive a flat control bus. Two read-only addresses report a 16-bit status input, and a further read-only address returns a fixed identity byte. Every other address in the 6-bit space reads as zero, and writes to those addresses are discarded.

Top module: `sreg_slave`

## Requirements
- R1: A frame has 16 serial clocks, and each bit is taken on a rising serial clock edge while select is low. Clock 1 carries the direction bit (1 = read, 0 = write). Clocks 2 to 7 carry the address, MSB first. Clock 8 carries a filler bit. Clocks 9 to 16 carry the data, MSB first.
- R2: A write to an address from 0x00 to 0x07 replaces byte `ctrl_bank[8*a+7 : 8*a]` with the data field once the 16th rising edge has been taken.
- R3: On a read, data bit 7 appears on `ser_dout` after the falling edge that follows the 8th rising edge. Each later falling edge presents the next lower bit. The host samples the bits on rising edges 9 to 16.
- R4: Address 0x3C reads `stat_word[15:8]`, address 0x3D reads `stat_word[7:0]`, and address 0x3F reads the identity parameter (default 0xA5). Writes to these three addresses change nothing.
- R5: A read from any other address at or above 0x08 returns 0x00, and a write to such an address changes nothing.
- R6: If select rises before the 16th rising edge, the frame has no effect.
- R7: `ser_dout` is held low while select is high.
- R8: After reset, every control register is zero and `ser_dout` is low.
- R9: The value of the filler bit has no effect on a read or on a write.
- R10: Each new select assertion starts a fresh frame, even when the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host |
| stat_word | input | 16 | Status value reported at 0x3C/0x3D |
| ctrl_bank | output | 64 | The eight control registers, address 0 in the low byte |

## Verification
The assertions assume that the serial clock is slow enough that each of its levels lasts longer than the synchronizer latency, so every edge is seen exactly once. They also assume that the data input is stable around each rising edge and that select changes only while the serial clock is low. The bench holds each serial clock level for eight fabric cycles, changes data and select only in the low phase, and samples read bits just before each rising edge.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int FRAME_N = 1 + ADDR_W + 1 + DATA_W;
  localparam int HDR_N   = 1 + ADDR_W + 1;
  localparam logic [ADDR_W-1:0] ADR_STAT_HI = 6'h3C;
  localparam logic [ADDR_W-1:0] ADR_STAT_LO = 6'h3D;
  localparam logic [ADDR_W-1:0] ADR_IDENT   = 6'h3F;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] d_rst,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= d_rst;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              sel,
  input  logic              din,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              wr_stb,
  output logic              dout
);
  localparam int CNT_W = $clog2(FRAME_N + 1);

  logic             sck_q;
  logic [CNT_W-1:0] cnt;
  logic             is_rd;
  logic [DATA_W-1:0] obuf;
  logic             rise, fall;

  assign rise = sck & ~sck_q;
  assign fall = ~sck & sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cnt    <= '0;
      is_rd  <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      wr_stb <= 1'b0;
      obuf   <= '0;
      dout   <= 1'b0;
    end else begin
      sck_q  <= sck;
      wr_stb <= 1'b0;
      if (!sel) begin
        cnt  <= '0;
        dout <= 1'b0;
        obuf <= '0;
      end else begin
        if (rise && cnt < CNT_W'(FRAME_N)) begin
          cnt <= cnt + 1'b1;
          if (cnt == 0)
            is_rd <= din;
          else if (cnt <= CNT_W'(ADDR_W))
            addr <= {addr[ADDR_W-2:0], din};
          else if (cnt >= CNT_W'(HDR_N))
            wdata <= {wdata[DATA_W-2:0], din};
          if (cnt == CNT_W'(FRAME_N - 1) && !is_rd)
            wr_stb <= 1'b1;
        end
        if (fall && is_rd) begin
          if (cnt == CNT_W'(HDR_N)) begin
            dout <= rdata[DATA_W-1];
            obuf <= {rdata[DATA_W-2:0], 1'b0};
          end else if (cnt > CNT_W'(HDR_N) && cnt < CNT_W'(FRAME_N)) begin
            dout <= obuf[DATA_W-1];
            obuf <= {obuf[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_N));
  assert_desel_restart_R10: assert property (@(posedge clk) disable iff (rst)
    !sel |=> cnt == 0);
  assert_dout_low_R7: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !dout);
  assert_wr_full_frame_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> cnt == CNT_W'(FRAME_N));
  assert_wr_one_shot_R2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int                RW_REGS  = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [2*DATA_W-1:0]       stat,
  output logic [DATA_W-1:0]         rdata,
  output logic [RW_REGS*DATA_W-1:0] ctrl
);
  localparam int IDX_W = (RW_REGS > 1) ? $clog2(RW_REGS) : 1;

  logic [DATA_W-1:0] regs [RW_REGS];
  logic              in_rw;

  assign in_rw = addr < ADDR_W'(RW_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RW_REGS; i++) regs[i] <= '0;
    end else if (we && in_rw) begin
      regs[addr[IDX_W-1:0]] <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < RW_REGS; g++) begin : g_flat
      assign ctrl[g*DATA_W +: DATA_W] = regs[g];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (in_rw)                    rdata = regs[addr[IDX_W-1:0]];
    else if (addr == ADR_STAT_HI) rdata = stat[2*DATA_W-1:DATA_W];
    else if (addr == ADR_STAT_LO) rdata = stat[DATA_W-1:0];
    else if (addr == ADR_IDENT)   rdata = ID_VALUE;
  end

  assert_rw_commit_R2: assert property (@(posedge clk) disable iff (rst)
    (we && in_rw) |=> regs[$past(addr[IDX_W-1:0])] == $past(wdata));
  assert_ro_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (we && !in_rw) |=> $stable(ctrl));
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter int                RW_REGS     = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_clk,
  input  logic                      ser_sel_n,
  input  logic                      ser_din,
  output logic                      ser_dout,
  input  logic [2*DATA_W-1:0]       stat_word,
  output logic [RW_REGS*DATA_W-1:0] ctrl_bank
);
  logic [2:0]        synced;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_wdata, b_rdata;
  logic              f_wr;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({ser_clk, ~ser_sel_n, ser_din}),
    .d_rst(3'b000),
    .d_out(synced)
  );

  sreg_frame u_frame (
    .clk(clk), .rst(rst),
    .sck(synced[2]), .sel(synced[1]), .din(synced[0]),
    .rdata(b_rdata), .addr(f_addr), .wdata(f_wdata),
    .wr_stb(f_wr), .dout(ser_dout)
  );

  sreg_bank #(.RW_REGS(RW_REGS), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst(rst), .we(f_wr), .addr(f_addr), .wdata(f_wdata),
    .stat(stat_word), .rdata(b_rdata), .ctrl(ctrl_bank)
  );
endmodule

// File: tb/sreg_slave_test.sv
module sreg_slave_test;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_sel_n = 1'b1;
  logic        ser_din = 1'b0;
  logic        ser_dout;
  logic [15:0] stat_word = 16'h5AC3;
  logic [63:0] ctrl_bank;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] mirror [8];

  always #2 clk = ~clk;

  sreg_slave uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .stat_word(stat_word),
    .ctrl_bank(ctrl_bank)
  );

  // {rw, addr[5:0], wdata[7:0], expected read[7:0]}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 6'h00, 8'h11, 8'h00},
    {1'b0, 6'h07, 8'hEE, 8'h00},
    {1'b1, 6'h00, 8'h00, 8'h11},
    {1'b1, 6'h07, 8'h00, 8'hEE},
    {1'b1, 6'h3C, 8'h00, 8'h5A},
    {1'b1, 6'h3D, 8'h00, 8'hC3},
    {1'b1, 6'h3F, 8'h00, 8'hA5},
    {1'b1, 6'h10, 8'h00, 8'h00},
    {1'b0, 6'h3C, 8'hFF, 8'h00},
    {1'b1, 6'h3C, 8'h00, 8'h5A},
    {1'b0, 6'h20, 8'h77, 8'h00},
    {1'b1, 6'h20, 8'h00, 8'h00},
    {1'b0, 6'h03, 8'h3C, 8'h00},
    {1'b1, 6'h03, 8'h00, 8'h3C}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] mirror_flat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mirror[i];
    return v;
  endfunction

  // Sends nbits of a frame; read bits are sampled just before rising edges 9..16.
  task automatic frame(input logic rw, input logic [5:0] a, input logic [7:0] d,
                       input logic dummy, input int nbits, output logic [7:0] rd);
    logic [15:0] bits;
    bits = {rw, a, dummy, d};
    rd = '0;
    ser_sel_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 1'b0;
      ser_din = bits[15-i];
      wait_clk(H);
      if (i >= 8) rd = {rd[6:0], ser_dout};
      ser_clk = 1'b1;
      wait_clk(H);
    end
    ser_clk = 1'b0;
    wait_clk(H);
    ser_sel_n = 1'b1;
    wait_clk(2*H);
    if (!rw && nbits == 16 && a < 6'd8) mirror[a[2:0]] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 8; i++) mirror[i] = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R8: reset state
    check(ctrl_bank, 64'h0, "R8 reset ctrl");
    check({63'h0, ser_dout}, 64'h0, "R8 reset dout");

    // R1 R2 R3 R4 R5: vector table
    foreach (VEC[k]) begin
      frame(VEC[k][22], VEC[k][21:16], VEC[k][15:8], 1'b0, 16, rd);
      if (VEC[k][22]) check({56'h0, rd}, {56'h0, VEC[k][7:0]}, "R1/R3/R4/R5 read");
      else            check(ctrl_bank, mirror_flat(), "R2/R4/R5 write");
    end

    // R7: output low while deselected, even right after a read ending in 1
    frame(1'b1, 6'h3F, 8'h00, 1'b0, 16, rd);
    check({63'h0, ser_dout}, 64'h0, "R7 dout deselected");

    // R6: aborted writes at 10 and 15 bits
    frame(1'b0, 6'h02, 8'hAB, 1'b0, 10, rd);
    check(ctrl_bank, mirror_flat(), "R6 abort at 10");
    frame(1'b0, 6'h02, 8'hAB, 1'b0, 15, rd);
    check(ctrl_bank, mirror_flat(), "R6 abort at 15");

    // R10: frame right after an abort starts clean
    frame(1'b0, 6'h05, 8'h5E, 1'b0, 16, rd);
    check(ctrl_bank, mirror_flat(), "R10 write after abort");
    frame(1'b1, 6'h05, 8'h00, 1'b0, 3, rd);
    frame(1'b1, 6'h05, 8'h00, 1'b0, 16, rd);
    check({56'h0, rd}, 64'h5E, "R10 read after abort");

    // R9: filler bit set
    frame(1'b0, 6'h06, 8'h81, 1'b1, 16, rd);
    check(ctrl_bank, mirror_flat(), "R9 write with filler");
    frame(1'b1, 6'h06, 8'h00, 1'b1, 16, rd);
    check({56'h0, rd}, 64'h81, "R9 read with filler");

    // R4: status follows input
    stat_word = 16'h9617;
    frame(1'b1, 6'h3D, 8'h00, 1'b0, 16, rd);
    check({56'h0, rd}, 64'h17, "R4 status low byte");

    // R8: reset clears bank
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 8; i++) mirror[i] = '0;
    check(ctrl_bank, 64'h0, "R8 reset after traffic");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule